// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block is a fully associative translation buffer for a small embedded processor core. Software loads each entry in two halves. The tag half holds the effective page number, a page-size code, a valid flag and an attribute byte. The other half holds the real page number. Each entry's process ID is taken from a current-process register at the moment the tag half is written. Every entry carries its own page size, so small and large pages can sit in the array side by side.

Two independent combinational ports compare an address against all entries in parallel:

- **Lookup port.** Returns hit, the matching index, the translated physical address and the entry's attribute byte.
- **Search port.** Returns the matching index, widened by one bit so that a miss reads as all ones. It also returns a condition nibble.

When several entries match, the lowest index is reported. A single-cycle invalidate input clears every valid flag. Permission checks, table walking and byte-order regions belong to other blocks.

Top module: `tlb_fa`

## Requirements
- R1: Synchronous reset clears every valid flag. After reset, both ports report a miss for any address.
- R2: A tag write stores the fields of `tag_data` into entry `wr_idx`:
  - the size code from bits [9:7];
  - the valid flag from bit 6;
  - the effective page number as bits [AW-1:10], with every bit below the page size forced to zero;
  - all of bits [7:0] as the attribute byte, which the lookup port returns on a hit.
- R3: The stored process ID is the value of `cur_pid` in the write cycle, not any part of the write data.
- R4: An entry matches only if its stored process ID is zero or equals the present `cur_pid`.
- R5: Size code n selects a page of 2^(10+2n) bytes. The page mask is the inverse of (page size − 1). An entry hits when (address AND mask) equals its stored page number.
- R6: `rpn_we` loads `rpn_data` into entry `wr_idx`. On a hit, the physical address is (RPN AND mask) OR (address AND NOT mask).
- R7: When several entries match, both ports report the lowest matching index.
- R8: On a hit, the search port returns {0, index} and `sx_cond` = 4'b0010. On a miss, it returns all ones (IDXW+1 bits) and `sx_cond` = 4'b0000.
- R9: An entry whose valid flag is clear never matches. `inv_all` clears all valid flags and wins over a tag write in the same cycle.
- R10: Writes take effect at the next rising clock edge. Before that edge, lookups see the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Clear all valid flags |
| cur_pid | input | PIDW | Current process ID |
| tag_we | input | 1 | Tag half write enable |
| rpn_we | input | 1 | Real page number write enable |
| wr_idx | input | IDXW | Entry written |
| tag_data | input | AW | Tag half write data |
| rpn_data | input | AW | Real page number write data |
| lk_addr | input | AW | Lookup effective address |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDXW | Lookup matching index |
| lk_pa | output | AW | Translated physical address |
| lk_attr | output | 8 | Attribute byte of matching entry |
| sx_addr | input | AW | Search effective address |
| sx_result | output | IDXW+1 | Search index, all ones on miss |
| sx_cond | output | 4 | Search condition nibble, bit 1 set on hit |

## Verification
The assertions assume the following about the inputs:
- reset is held high from time zero through the first edges, so every `$past` sample lies after a defined state;
- `wr_idx` is a legal index whenever a write strobe is high.

The bench drives every input at the falling edge and keeps reset asserted for several cycles. Every index it writes lies inside the array.

The page-boundary checks rely on the size codes staying within the address width. The default 32-bit address leaves room for the largest page of 16 MB, and the bench sweeps all eight codes with that width.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;
  localparam int MIN_PAGE_LOG2 = 10;
  localparam int SIZE_W        = 3;
  localparam int SIZE_LSB      = 7;
  localparam int VALID_BIT     = 6;
  localparam int ATTR_W        = 8;
  localparam logic [3:0] COND_HIT = 4'b0010;
endpackage

// File: rtl/tlb_fa_match.sv
module tlb_fa_match
  import tlb_fa_pkg::*;
#(
  parameter int AW   = 32,
  parameter int PIDW = 8
) (
  input  logic              valid,
  input  logic [AW-1:0]     epn,
  input  logic [SIZE_W-1:0] size,
  input  logic [PIDW-1:0]   pid,
  input  logic [PIDW-1:0]   cur_pid,
  input  logic [AW-1:0]     addr,
  output logic              hit
);
  logic [AW-1:0] mask;
  logic          pid_ok;

  always_comb begin
    mask   = ~((AW'(1) << (MIN_PAGE_LOG2 + 2 * int'(size))) - AW'(1));
    pid_ok = (pid == '0) || (pid == cur_pid);
    hit    = valid && pid_ok && ((addr & mask) == epn);
  end
endmodule

// File: rtl/tlb_fa_prio.sv
module tlb_fa_prio #(
  parameter int N    = 64,
  parameter int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    req,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_fa_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int AW      = 32,
  parameter int PIDW    = 8,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_all,
  input  logic [PIDW-1:0]   cur_pid,
  input  logic              tag_we,
  input  logic              rpn_we,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [AW-1:0]     tag_data,
  input  logic [AW-1:0]     rpn_data,
  input  logic [AW-1:0]     lk_addr,
  output logic              lk_hit,
  output logic [IDXW-1:0]   lk_idx,
  output logic [AW-1:0]     lk_pa,
  output logic [ATTR_W-1:0] lk_attr,
  input  logic [AW-1:0]     sx_addr,
  output logic [IDXW:0]     sx_result,
  output logic [3:0]        sx_cond
);
  function automatic logic [AW-1:0] pmask(input logic [SIZE_W-1:0] s);
    return ~((AW'(1) << (MIN_PAGE_LOG2 + 2 * int'(s))) - AW'(1));
  endfunction

  logic [ENTRIES-1:0] valid_q;
  logic [AW-1:0]      epn_q  [ENTRIES];
  logic [SIZE_W-1:0]  size_q [ENTRIES];
  logic [PIDW-1:0]    pid_q  [ENTRIES];
  logic [ATTR_W-1:0]  attr_q [ENTRIES];
  logic [AW-1:0]      rpn_q  [ENTRIES];

  logic [SIZE_W-1:0] wr_size;
  logic [AW-1:0]     wr_epn;

  always_comb begin
    wr_size = tag_data[SIZE_LSB +: SIZE_W];
    wr_epn  = tag_data & ~((AW'(1) << MIN_PAGE_LOG2) - AW'(1)) & pmask(wr_size);
  end

  always_ff @(posedge clk) begin
    if (rst || inv_all) begin
      valid_q <= '0;
    end else if (tag_we) begin
      valid_q[wr_idx] <= tag_data[VALID_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we) begin
      epn_q[wr_idx]  <= wr_epn;
      size_q[wr_idx] <= wr_size;
      pid_q[wr_idx]  <= cur_pid;
      attr_q[wr_idx] <= tag_data[ATTR_W-1:0];
    end
    if (rpn_we) begin
      rpn_q[wr_idx] <= rpn_data;
    end
  end

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] sx_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    tlb_fa_match #(.AW(AW), .PIDW(PIDW)) u_lk (
      .valid(valid_q[g]), .epn(epn_q[g]), .size(size_q[g]), .pid(pid_q[g]),
      .cur_pid(cur_pid), .addr(lk_addr), .hit(lk_match[g])
    );
    tlb_fa_match #(.AW(AW), .PIDW(PIDW)) u_sx (
      .valid(valid_q[g]), .epn(epn_q[g]), .size(size_q[g]), .pid(pid_q[g]),
      .cur_pid(cur_pid), .addr(sx_addr), .hit(sx_match[g])
    );
  end

  logic            sx_hit;
  logic [IDXW-1:0] sx_idx;

  tlb_fa_prio #(.N(ENTRIES), .IDXW(IDXW)) u_lk_prio (
    .req(lk_match), .any(lk_hit), .idx(lk_idx)
  );
  tlb_fa_prio #(.N(ENTRIES), .IDXW(IDXW)) u_sx_prio (
    .req(sx_match), .any(sx_hit), .idx(sx_idx)
  );

  logic [AW-1:0] lk_mask;

  always_comb begin
    lk_mask   = pmask(size_q[lk_idx]);
    lk_pa     = (rpn_q[lk_idx] & lk_mask) | (lk_addr & ~lk_mask);
    lk_attr   = attr_q[lk_idx];
    sx_result = sx_hit ? {1'b0, sx_idx} : '1;
    sx_cond   = sx_hit ? COND_HIT : 4'b0000;
  end

  // Assertions
  assert_inv_clears_R9: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (valid_q == '0));

  assert_valid_written_R2: assert property (@(posedge clk) disable iff (rst)
    (tag_we && !inv_all) |=> (valid_q[$past(wr_idx)] == $past(tag_data[VALID_BIT])));

  assert_pid_captured_R3: assert property (@(posedge clk) disable iff (rst)
    tag_we |=> (pid_q[$past(wr_idx)] == $past(cur_pid)));

  assert_hit_legal_R4: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (valid_q[lk_idx] && (pid_q[lk_idx] == '0 || pid_q[lk_idx] == cur_pid)));

  assert_offset_kept_R6: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (((lk_pa ^ lk_addr) & ((AW'(1) << (MIN_PAGE_LOG2 + 2 * int'(size_q[lk_idx]))) - AW'(1))) == '0));

  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> ((lk_match & ((ENTRIES'(1) << lk_idx) - ENTRIES'(1))) == '0));

  assert_miss_ones_R8: assert property (@(posedge clk) disable iff (rst)
    (sx_match == '0) |-> (&sx_result && sx_cond == 4'b0000));
endmodule

// File: tb/tlb_fa_test.sv
module tlb_fa_test;
  localparam int N    = 64;
  localparam int AW   = 32;
  localparam int PIDW = 8;
  localparam int IDXW = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inv_all = 1'b0;
  logic [PIDW-1:0]   cur_pid = '0;
  logic              tag_we = 1'b0;
  logic              rpn_we = 1'b0;
  logic [IDXW-1:0]   wr_idx = '0;
  logic [AW-1:0]     tag_data = '0;
  logic [AW-1:0]     rpn_data = '0;
  logic [AW-1:0]     lk_addr = '0;
  logic              lk_hit;
  logic [IDXW-1:0]   lk_idx;
  logic [AW-1:0]     lk_pa;
  logic [7:0]        lk_attr;
  logic [AW-1:0]     sx_addr = '0;
  logic [IDXW:0]     sx_result;
  logic [3:0]        sx_cond;

  tlb_fa #(.ENTRIES(N), .AW(AW), .PIDW(PIDW)) uut (
    .clk(clk), .rst(rst), .inv_all(inv_all), .cur_pid(cur_pid),
    .tag_we(tag_we), .rpn_we(rpn_we), .wr_idx(wr_idx),
    .tag_data(tag_data), .rpn_data(rpn_data),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_pa(lk_pa),
    .lk_attr(lk_attr), .sx_addr(sx_addr), .sx_result(sx_result), .sx_cond(sx_cond)
  );

  always #10 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic            m_v   [N];
  logic [AW-1:0]   m_epn [N];
  logic [2:0]      m_sz  [N];
  logic [PIDW-1:0] m_pid [N];
  logic [7:0]      m_attr[N];
  logic [AW-1:0]   m_rpn [N];

  function automatic logic [AW-1:0] msk(input logic [2:0] s);
    return ~((32'd1 << (10 + 2 * int'(s))) - 32'd1);
  endfunction

  function automatic int ref_find(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && (m_pid[i] == 0 || m_pid[i] == cur_pid) && ((a & msk(m_sz[i])) == m_epn[i]))
        return i;
    end
    return -1;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
  endtask

  task automatic write_tag(input int idx, input logic [AW-1:0] d);
    @(negedge clk);
    wr_idx = IDXW'(idx); tag_data = d; tag_we = 1'b1;
    @(negedge clk);
    tag_we = 1'b0;
    m_sz[idx]   = d[9:7];
    m_v[idx]    = d[6];
    m_epn[idx]  = d & 32'hFFFF_FC00 & msk(d[9:7]);
    m_pid[idx]  = cur_pid;
    m_attr[idx] = d[7:0];
  endtask

  task automatic write_rpn(input int idx, input logic [AW-1:0] d);
    @(negedge clk);
    wr_idx = IDXW'(idx); rpn_data = d; rpn_we = 1'b1;
    @(negedge clk);
    rpn_we = 1'b0;
    m_rpn[idx] = d;
  endtask

  task automatic check(input logic [AW-1:0] a, input string req);
    int e;
    logic [AW-1:0] epa;
    logic [IDXW:0] esr;
    logic [3:0] ec;
    bit bad;
    lk_addr = a; sx_addr = a;
    #1;
    e = ref_find(a);
    tests++;
    bad = 1'b0;
    if (e < 0) begin
      esr = '1; ec = 4'b0000;
      if (lk_hit !== 1'b0 || sx_result !== esr || sx_cond !== ec) bad = 1'b1;
      if (bad) $display("FAIL %s addr=%h: hit=%b sx=%h cond=%b expected hit=0 sx=%h cond=%b",
                        req, a, lk_hit, sx_result, sx_cond, esr, ec);
    end else begin
      epa = (m_rpn[e] & msk(m_sz[e])) | (a & ~msk(m_sz[e]));
      esr = {1'b0, IDXW'(e)}; ec = 4'b0010;
      if (lk_hit !== 1'b1 || lk_idx !== IDXW'(e) || lk_pa !== epa || lk_attr !== m_attr[e] ||
          sx_result !== esr || sx_cond !== ec) bad = 1'b1;
      if (bad) $display("FAIL %s addr=%h: hit=%b idx=%0d pa=%h attr=%h sx=%h cond=%b expected idx=%0d pa=%h attr=%h sx=%h cond=%b",
                        req, a, lk_hit, lk_idx, lk_pa, lk_attr, sx_result, sx_cond,
                        e, epa, m_attr[e], esr, ec);
    end
    if (bad) fails++;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] r;
    logic [AW-1:0] d;
    logic [AW-1:0] base;
    logic [AW-1:0] pg;
    int sz;
    model_clear();
    for (int i = 0; i < N; i++) begin
      m_rpn[i] = '0; m_sz[i] = '0; m_epn[i] = '0; m_pid[i] = '0; m_attr[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: nothing matches after reset
    check(32'h0000_0000, "R1");
    check(32'hFFFF_FFFF, "R1");

    // R10: before the edge the old contents are seen
    cur_pid = 8'd0;
    @(negedge clk);
    wr_idx = 6'd2; tag_data = 32'h0000_5040; tag_we = 1'b1;
    check(32'h0000_5000, "R10");
    @(negedge clk);
    tag_we = 1'b0;
    m_sz[2] = 3'd0; m_v[2] = 1'b1; m_epn[2] = 32'h0000_5000; m_pid[2] = 8'd0; m_attr[2] = 8'h40;
    check(32'h0000_5000, "R10");
    write_rpn(2, 32'hABCD_E000);
    check(32'h0000_53FF, "R6");
    check(32'h0000_5400, "R5");

    // R2: low bits below the page size are cleared, attribute kept
    write_tag(5, 32'h1234_5000 | (32'd3 << 7) | 32'h40 | 32'h2F);
    write_rpn(5, 32'h8765_4321);
    check(32'h1234_0000, "R2");
    check(32'h1234_FFFF, "R2");
    check(32'h1235_0000, "R5");

    // R9: invalid entry never matches
    write_tag(10, 32'h7700_0000);
    check(32'h7700_0000, "R9");

    // R7: lowest matching index wins
    write_tag(7, 32'h4400_0040);
    write_rpn(7, 32'h1111_1000);
    write_tag(3, 32'h4400_0040);
    write_rpn(3, 32'h2222_2000);
    check(32'h4400_0123, "R7");

    // R3/R4: PID captured at write, matched against current PID
    cur_pid = 8'd9;
    write_tag(12, 32'h9900_0040);
    write_rpn(12, 32'h3300_0000);
    check(32'h9900_0010, "R3");
    cur_pid = 8'd4;
    check(32'h9900_0010, "R4");
    check(32'h0000_5000, "R4");
    cur_pid = 8'd9;
    check(32'h9900_0010, "R4");

    // R9: invalidate-all wins over a same-cycle tag write
    @(negedge clk);
    inv_all = 1'b1; wr_idx = 6'd20; tag_data = 32'h5500_0040; tag_we = 1'b1;
    @(negedge clk);
    inv_all = 1'b0; tag_we = 1'b0;
    model_clear();
    check(32'h5500_0000, "R9");
    check(32'h0000_5000, "R1");

    // R5/R6/R7/R8: sweep over all entries and size codes
    r = 32'h1ACE_B00C;
    for (int i = 0; i < N; i++) begin
      cur_pid = (i % 3 == 0) ? 8'd0 : 8'(i % 4 + 1);
      r = r * 32'd1103515245 + 32'd12345;
      sz = i % 8;
      d = (r & 32'hFFFF_FC00) | (32'(sz) << 7) | ((i % 11 == 5) ? 32'h0 : 32'h40) | (r & 32'h3F);
      write_tag(i, d);
      r = r * 32'd1103515245 + 32'd12345;
      write_rpn(i, r);
    end
    for (int p = 1; p <= 4; p++) begin
      cur_pid = 8'(p);
      for (int i = 0; i < N; i++) begin
        base = m_epn[i];
        pg = 32'd1 << (10 + 2 * int'(m_sz[i]));
        check(base, "R5");
        check(base + pg - 32'd1, "R6");
        check(base + pg, "R8");
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule